// File: doc/BRIEF.md
# Verify-and-Allocate Row Write Controller

This controller carries out one row write for a resistive memory whose cells can fail permanently when written. Each request goes through three steps. The controller reads the row, writes only the cells whose value must change, and reads the row back. If the read-back logical value disagrees with the requested data, a cell is stuck. The controller then repairs the row by claiming the next unused correction entry and pointing it at the failing bit. It then verifies again. This loop repeats until the row reads back correctly or no entry is left.

The row holds `DATA_W` data cells, `N_ENT` correction entries and a full flag. Each entry is a `PTR_W`-bit pointer plus one replacement cell. The replacement cell is differential: the logical value of a bit is the stored cell XOR the replacement bits of every active entry aimed at it, applied in entry order. While the full flag is clear, the low `N_ENT-1` cells of the last entry hold a unary count of the active lower entries. The last entry is claimed last. Claiming it sets the full flag, and its cells then serve as an ordinary pointer and replacement bit. The array port has a read strobe and a bit-masked write strobe. Read data arrives one cycle after the read strobe, and a write lands at the clock edge that ends its strobe cycle.

Top module: `ecp_wr_ctrl`

## Requirements
- R1: Out of reset the controller is idle: `req_ready_o` is 1, `done_o` and `dead_o` are 0, and neither array strobe is active.
- R2: Each request reads the row, issues one masked write, and then performs a verify read. Reads and writes never overlap. `done_o` comes two cycles after a read strobe, and a row with no faults needs exactly one write.
- R3: On a row without active entries, the first write's mask covers exactly the data cells where the old value differs from the requested value, and no metadata cell.
- R4: A verify mismatch is repaired by the lowest-index inactive entry. That entry's pointer (bits `DATA_W+k*(PTR_W+1)` upward) is set to the lowest mismatching bit. The entry is activated by setting unary bit k at row bit `DATA_W+(N_ENT-1)*(PTR_W+1)+k`.
- R5: The logical row value is the data cells, with each active entry in ascending order XORing its replacement bit (bit `PTR_W` of the entry) into the bit its pointer selects. After `done_o`, this value equals the requested data.
- R6: Claiming entry `N_ENT-1` sets the full flag (top row bit). After that, all entries are active, and the last entry's cells hold a pointer instead of the count.
- R7: If a replacement cell of an active entry is stuck, a higher-index entry is claimed for the same data bit.
- R8: If a stuck pointer cell makes an entry select a healthy bit, that entry's replacement bit is written as 0, so it does no harm. One further entry is claimed for the failing bit.
- R9: If a mismatch remains when the full flag is set, `dead_o` pulses. A request never issues more than `2*N_ENT+1` writes.
- R10: `req_ready_o` is high only when idle, and a request is accepted when `req_valid_i` and `req_ready_o` are both high. `done_o` and `dead_o` are exclusive single-cycle pulses, and the controller is idle in the next cycle.
- R11: A later write to a repaired bit toggles the replacement bit of the highest active entry aimed at it, without claiming a new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Write request valid |
| req_data_i | input | DATA_W | Requested row data |
| req_ready_o | output | 1 | Controller idle, request accepted |
| done_o | output | 1 | Pulse: row verified correct |
| dead_o | output | 1 | Pulse: row uncorrectable |
| arr_rd_o | output | 1 | Array read strobe |
| arr_rdata_i | input | ROW_W | Row read data, valid one cycle after strobe |
| arr_wr_o | output | 1 | Array write strobe |
| arr_wmask_o | output | ROW_W | Per-cell write enable |
| arr_wdata_o | output | ROW_W | Write values for masked cells |

## Verification
On every cycle, the assertions check the handshake and pulse rules, that reads and writes never overlap, that completion follows a verify read, and that writes per request stay within the entry budget. Only the bench scenarios can show the remaining behaviour. This covers which cells the first write touches, which entry is claimed and where its pointer lands, and the unary count and full flag in the stored row. It also covers recovery from stuck replacement and pointer cells, and the final logical value. The bench drives all of these against a stuck-cell row model.

// File: rtl/ecp_pkg.sv
`timescale 1ns/1ps
package ecp_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PRE_RD, S_PRE_CAP, S_WR, S_VER_RD, S_VER_CAP,
    S_EVAL, S_ALLOC, S_CHK_RD, S_CHK_CAP, S_REPL
  } ecp_state_e;
endpackage

// File: rtl/ecp_row_decode.sv
`timescale 1ns/1ps
module ecp_row_decode #(
  parameter int DATA_W = 16,
  parameter int N_ENT  = 4,
  localparam int PTR_W = $clog2(DATA_W),
  localparam int ENT_W = PTR_W + 1,
  localparam int IDX_W = $clog2(N_ENT),
  localparam int ROW_W = DATA_W + N_ENT * ENT_W + 1,
  localparam int CNT_BASE = DATA_W + (N_ENT - 1) * ENT_W
) (
  input  logic [ROW_W-1:0]                 row_i,
  output logic [DATA_W-1:0]                corr_o,
  output logic [DATA_W-1:0]                hit_o,
  output logic [DATA_W-1:0][IDX_W-1:0]     hidx_o,
  output logic [N_ENT-1:0][PTR_W-1:0]      ptr_o,
  output logic [N_ENT-1:0]                 repl_o,
  output logic                             full_o,
  output logic [IDX_W-1:0]                 free_o
);
  logic [N_ENT-1:0] act;

  always_comb begin
    full_o = row_i[ROW_W-1];
    corr_o = row_i[DATA_W-1:0];
    hit_o  = '0;
    hidx_o = '0;
    free_o = '0;
    for (int k = 0; k < N_ENT; k++) begin
      ptr_o[k]  = row_i[DATA_W + k*ENT_W +: PTR_W];
      repl_o[k] = row_i[DATA_W + k*ENT_W + PTR_W];
      if (k < N_ENT - 1) begin
        act[k] = full_o | row_i[CNT_BASE + k];
        if (row_i[CNT_BASE + k]) free_o = free_o + IDX_W'(1);
      end else begin
        act[k] = full_o;
      end
      // ascending order: later entries override earlier ones
      if (act[k] && int'(ptr_o[k]) < DATA_W) begin
        corr_o[ptr_o[k]] = corr_o[ptr_o[k]] ^ repl_o[k];
        hit_o[ptr_o[k]]  = 1'b1;
        hidx_o[ptr_o[k]] = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/ecp_write_plan.sv
`timescale 1ns/1ps
module ecp_write_plan #(
  parameter int DATA_W = 16,
  parameter int N_ENT  = 4,
  localparam int PTR_W = $clog2(DATA_W),
  localparam int ENT_W = PTR_W + 1,
  localparam int IDX_W = $clog2(N_ENT),
  localparam int ROW_W = DATA_W + N_ENT * ENT_W + 1
) (
  input  logic [ROW_W-1:0]             row_i,
  input  logic [DATA_W-1:0]            corr_i,
  input  logic [DATA_W-1:0]            hit_i,
  input  logic [DATA_W-1:0][IDX_W-1:0] hidx_i,
  input  logic [DATA_W-1:0]            des_i,
  output logic [ROW_W-1:0]             wmask_o,
  output logic [ROW_W-1:0]             wdata_o
);
  always_comb begin
    wmask_o = '0;
    for (int b = 0; b < DATA_W; b++) begin
      if (corr_i[b] != des_i[b]) begin
        if (hit_i[b]) wmask_o[DATA_W + int'(hidx_i[b])*ENT_W + PTR_W] = 1'b1;
        else          wmask_o[b] = 1'b1;
      end
    end
    wdata_o = row_i ^ wmask_o;  // flip only the cells that change
  end
endmodule

// File: rtl/ecp_alloc.sv
`timescale 1ns/1ps
module ecp_alloc #(
  parameter int DATA_W = 16,
  parameter int N_ENT  = 4,
  localparam int PTR_W = $clog2(DATA_W),
  localparam int ENT_W = PTR_W + 1,
  localparam int IDX_W = $clog2(N_ENT),
  localparam int ROW_W = DATA_W + N_ENT * ENT_W + 1,
  localparam int CNT_BASE = DATA_W + (N_ENT - 1) * ENT_W
) (
  input  logic [DATA_W-1:0] corr_i,
  input  logic [DATA_W-1:0] des_i,
  input  logic [IDX_W-1:0]  free_i,
  output logic              fail_o,
  output logic [ROW_W-1:0]  amask_o,
  output logic [ROW_W-1:0]  adata_o
);
  logic [DATA_W-1:0] miss;
  logic [PTR_W-1:0]  fail_idx;

  always_comb begin
    miss     = corr_i ^ des_i;
    fail_o   = |miss;
    fail_idx = '0;
    for (int b = DATA_W - 1; b >= 0; b--)
      if (miss[b]) fail_idx = PTR_W'(b);
  end

  // pointer written, replacement cleared, entry activated in one write
  always_comb begin
    amask_o = '0;
    adata_o = '0;
    amask_o[DATA_W + int'(free_i)*ENT_W +: ENT_W] = '1;
    adata_o[DATA_W + int'(free_i)*ENT_W +: PTR_W] = fail_idx;
    if (int'(free_i) == N_ENT - 1) begin
      amask_o[ROW_W-1] = 1'b1;
      adata_o[ROW_W-1] = 1'b1;
    end else begin
      amask_o[CNT_BASE + int'(free_i)] = 1'b1;
      adata_o[CNT_BASE + int'(free_i)] = 1'b1;
    end
  end
endmodule

// File: rtl/ecp_wr_ctrl.sv
`timescale 1ns/1ps
module ecp_wr_ctrl
  import ecp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int N_ENT  = 4,
  localparam int PTR_W = $clog2(DATA_W),
  localparam int ENT_W = PTR_W + 1,
  localparam int IDX_W = $clog2(N_ENT),
  localparam int ROW_W = DATA_W + N_ENT * ENT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              req_ready_o,
  output logic              done_o,
  output logic              dead_o,
  output logic              arr_rd_o,
  input  logic [ROW_W-1:0]  arr_rdata_i,
  output logic              arr_wr_o,
  output logic [ROW_W-1:0]  arr_wmask_o,
  output logic [ROW_W-1:0]  arr_wdata_o
);
  ecp_state_e        state_q, state_d;
  logic [ROW_W-1:0]  row_q;
  logic [DATA_W-1:0] des_q;
  logic [IDX_W-1:0]  alloc_q;

  logic [DATA_W-1:0]            d_corr, d_hit;
  logic [DATA_W-1:0][IDX_W-1:0] d_hidx;
  logic [N_ENT-1:0][PTR_W-1:0]  d_ptr;
  logic [N_ENT-1:0]             d_repl;
  logic                         d_full;
  logic [IDX_W-1:0]             d_free;
  logic [ROW_W-1:0]             p_mask, p_data, a_mask, a_data;
  logic                         fail;
  logic [PTR_W-1:0]             p_sel;
  logic                         r_new;

  ecp_row_decode #(.DATA_W(DATA_W), .N_ENT(N_ENT)) u_dec (
    .row_i(row_q), .corr_o(d_corr), .hit_o(d_hit), .hidx_o(d_hidx),
    .ptr_o(d_ptr), .repl_o(d_repl), .full_o(d_full), .free_o(d_free)
  );

  ecp_write_plan #(.DATA_W(DATA_W), .N_ENT(N_ENT)) u_plan (
    .row_i(row_q), .corr_i(d_corr), .hit_i(d_hit), .hidx_i(d_hidx),
    .des_i(des_q), .wmask_o(p_mask), .wdata_o(p_data)
  );

  ecp_alloc #(.DATA_W(DATA_W), .N_ENT(N_ENT)) u_alloc (
    .corr_i(d_corr), .des_i(des_q), .free_i(d_free),
    .fail_o(fail), .amask_o(a_mask), .adata_o(a_data)
  );

  // second phase: replacement value from the pointer as actually stored
  always_comb begin
    p_sel = d_ptr[alloc_q];
    r_new = 1'b0;
    if (int'(p_sel) < DATA_W)
      r_new = d_repl[alloc_q] ^ des_q[p_sel] ^ d_corr[p_sel];
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    if (req_valid_i) state_d = S_PRE_RD;
      S_PRE_RD:  state_d = S_PRE_CAP;
      S_PRE_CAP: state_d = S_WR;
      S_WR:      state_d = S_VER_RD;
      S_VER_RD:  state_d = S_VER_CAP;
      S_VER_CAP: state_d = S_EVAL;
      S_EVAL:    state_d = (!fail || d_full) ? S_IDLE : S_ALLOC;
      S_ALLOC:   state_d = S_CHK_RD;
      S_CHK_RD:  state_d = S_CHK_CAP;
      S_CHK_CAP: state_d = S_REPL;
      S_REPL:    state_d = S_VER_RD;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      row_q   <= '0;
      des_q   <= '0;
      alloc_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && req_valid_i) des_q <= req_data_i;
      if (state_q == S_PRE_CAP || state_q == S_VER_CAP || state_q == S_CHK_CAP)
        row_q <= arr_rdata_i;
      if (state_q == S_EVAL) alloc_q <= d_free;
    end
  end

  always_comb begin
    arr_wmask_o = '0;
    arr_wdata_o = '0;
    case (state_q)
      S_WR: begin
        arr_wmask_o = p_mask;
        arr_wdata_o = p_data;
      end
      S_ALLOC: begin
        arr_wmask_o = a_mask;
        arr_wdata_o = a_data;
      end
      S_REPL: begin
        arr_wmask_o[DATA_W + int'(alloc_q)*ENT_W + PTR_W] = 1'b1;
        arr_wdata_o[DATA_W + int'(alloc_q)*ENT_W + PTR_W] = r_new;
      end
      default: ;
    endcase
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign arr_rd_o    = (state_q == S_PRE_RD) || (state_q == S_VER_RD) || (state_q == S_CHK_RD);
  assign arr_wr_o    = (state_q == S_WR) || (state_q == S_ALLOC) || (state_q == S_REPL);
  assign done_o      = (state_q == S_EVAL) && !fail;
  assign dead_o      = (state_q == S_EVAL) && fail && d_full;
endmodule

// File: rtl/ecp_wr_ctrl_chk.sv
`timescale 1ns/1ps
module ecp_wr_ctrl_chk #(
  parameter int N_ENT = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic done_o,
  input logic dead_o,
  input logic arr_rd_o,
  input logic arr_wr_o
);
  logic [7:0] wr_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         wr_cnt <= '0;
    else if (req_valid_i && req_ready_o) wr_cnt <= '0;
    else if (arr_wr_o)                   wr_cnt <= wr_cnt + 8'd1;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!arr_rd_o && !arr_wr_o));

  assert_no_overlap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(arr_rd_o && arr_wr_o));

  assert_done_after_verify_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(arr_rd_o, 2));

  assert_write_budget_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(wr_cnt) <= 2 * N_ENT + 1);

  assert_excl_status_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && dead_o));

  assert_pulse_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || dead_o) |=> (!done_o && !dead_o && req_ready_o));

  assert_accept_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
endmodule

bind ecp_wr_ctrl ecp_wr_ctrl_chk #(.N_ENT(N_ENT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o), .done_o(done_o), .dead_o(dead_o),
  .arr_rd_o(arr_rd_o), .arr_wr_o(arr_wr_o)
);

// File: tb/ecp_wr_ctrl_bench.sv
`timescale 1ns/1ps
module ecp_wr_ctrl_bench;
  localparam int D = 16, N = 4, PW = 4, EW = 5;
  localparam int RW = D + N*EW + 1;
  localparam int CB = D + (N-1)*EW;
  localparam int FB = RW - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0;
  logic [D-1:0]  req_data = '0;
  logic          req_ready, done, dead, arr_rd, arr_wr;
  logic [RW-1:0] arr_wmask, arr_wdata;
  logic [RW-1:0] mem = '0, stuck_m = '0, stuck_v = '0, rdata = '0, ld_val = '0, first_mask = '0;
  logic          ld = 1'b0;
  int            wcnt = 0;
  int            n_chk = 0, n_bad = 0;

  ecp_wr_ctrl u_ecp_wr_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_data_i(req_data),
    .req_ready_o(req_ready), .done_o(done), .dead_o(dead),
    .arr_rd_o(arr_rd), .arr_rdata_i(rdata), .arr_wr_o(arr_wr),
    .arr_wmask_o(arr_wmask), .arr_wdata_o(arr_wdata)
  );

  function automatic logic [RW-1:0] pin(input logic [RW-1:0] v);
    return (v & ~stuck_m) | (stuck_v & stuck_m);
  endfunction

  // row model with stuck cells
  always @(posedge clk) begin
    if (ld) mem <= pin(ld_val);
    else if (arr_wr) mem <= pin((mem & ~arr_wmask) | (arr_wdata & arr_wmask));
    if (arr_rd) rdata <= mem;
  end

  always @(posedge clk) begin
    if (req_valid && req_ready) wcnt <= 0;
    else if (arr_wr) begin
      if (wcnt == 0) first_mask <= arr_wmask;
      wcnt <= wcnt + 1;
    end
  end

  function automatic bit e_act(input logic [RW-1:0] m, input int k);
    return m[FB] || (k < N-1 && m[CB+k]);
  endfunction
  function automatic int e_ptr(input logic [RW-1:0] m, input int k);
    return int'(m[D+k*EW +: PW]);
  endfunction
  function automatic bit e_repl(input logic [RW-1:0] m, input int k);
    return m[D+k*EW+PW];
  endfunction
  function automatic logic [D-1:0] logical(input logic [RW-1:0] m);
    logic [D-1:0] v = m[D-1:0];
    for (int k = 0; k < N; k++)
      if (e_act(m, k)) v[e_ptr(m, k)] = v[e_ptr(m, k)] ^ e_repl(m, k);
    return v;
  endfunction
  function automatic int used(input logic [RW-1:0] m);
    int c = 0;
    if (m[FB]) return N;
    for (int k = 0; k < N-1; k++) c += int'(m[CB+k]);
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [RW-1:0] v);
    @(negedge clk); ld = 1'b1; ld_val = v;
    @(negedge clk); ld = 1'b0;
  endtask

  // res: 1 done, 2 dead, 0 hung
  task automatic run_write(input logic [D-1:0] d, output int res);
    res = 0;
    @(negedge clk); req_valid = 1'b1; req_data = d;
    @(negedge clk); req_valid = 1'b0;
    for (int t = 0; t < 200; t++) begin
      if (done) begin res = 1; break; end
      if (dead) begin res = 2; break; end
      @(negedge clk);
    end
    @(negedge clk);
    chk(!done && !dead && req_ready, "R10 pulse then idle", {done, dead, req_ready}, 3'b001);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int res;
    logic [D-1:0] d, prev;
    int cl[5] = '{1, 3, 6, 11, 14};

    @(negedge clk);
    chk(req_ready && !done && !dead && !arr_rd && !arr_wr, "R1 reset state",
        {req_ready, done, dead, arr_rd, arr_wr}, 5'b10000);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !arr_rd && !arr_wr, "R1 idle after reset", {req_ready, arr_rd, arr_wr}, 3'b100);

    // fault-free sweep
    load('0); prev = '0;
    for (int i = 0; i < 48; i++) begin
      d = 16'((i * 16'h9E37) ^ (i << 5));
      run_write(d, res);
      chk(res == 1, "R2 fault-free completes", res, 1);
      chk(wcnt == 1, "R2 single write", wcnt, 1);
      chk(first_mask == {{(RW-D){1'b0}}, prev ^ d}, "R3 changed cells only", first_mask, {{(RW-D){1'b0}}, prev ^ d});
      chk(logical(mem) == d, "R5 read value", logical(mem), d);
      chk(used(mem) == 0, "R4 no entry claimed", used(mem), 0);
      prev = d;
    end

    // one stuck data cell, both stuck values
    for (int b = 0; b < D; b++) begin
      for (int sv = 0; sv < 2; sv++) begin
        stuck_m = '0; stuck_m[b] = 1'b1;
        stuck_v = '0; stuck_v[b] = sv[0];
        load('0);
        d = sv ? (16'hA5C3 & ~(16'd1 << b)) : (16'hA5C3 | (16'd1 << b));
        run_write(d, res);
        chk(res == 1, "R4 single fault repaired", res, 1);
        chk(e_ptr(mem, 0) == b, "R4 entry 0 pointer", e_ptr(mem, 0), b);
        chk(mem[CB +: 3] == 3'b001, "R4 unary count", mem[CB +: 3], 3'b001);
        chk(wcnt == 3, "R4 write count", wcnt, 3);
        chk(logical(mem) == d, "R5 repaired value", logical(mem), d);
        run_write(~d, res);
        chk(res == 1 && used(mem) == 1, "R11 rewrite keeps entries", used(mem), 1);
        chk(logical(mem) == ~d, "R11 rewrite value", logical(mem), ~d);
      end
    end

    // 0..5 stuck cells: capacity and dead row
    for (int k = 0; k <= 5; k++) begin
      stuck_m = '0; stuck_v = '0;
      for (int j = 0; j < k; j++) stuck_m[cl[j]] = 1'b1;
      load('0);
      run_write(16'hFFFF, res);
      if (k <= N) begin
        chk(res == 1, "R6 within capacity", res, 1);
        chk(used(mem) == k, "R4 entries used", used(mem), k);
        chk(logical(mem) == 16'hFFFF, "R5 value", logical(mem), 16'hFFFF);
        chk(mem[FB] == (k == N), "R6 full flag", mem[FB], k == N);
        for (int j = 0; j < k; j++)
          chk(e_ptr(mem, j) == cl[j], "R4 lowest first", e_ptr(mem, j), cl[j]);
        if (k < N) chk(int'(mem[CB +: 3]) == (1 << k) - 1, "R4 unary bits", mem[CB +: 3], (1 << k) - 1);
      end else begin
        chk(res == 2, "R9 dead row", res, 2);
        chk(wcnt == 2*N + 1, "R9 write budget", wcnt, 2*N + 1);
      end
    end

    // stuck replacement cell in entry 0
    stuck_m = '0; stuck_v = '0;
    stuck_m[3] = 1'b1; stuck_m[D + PW] = 1'b1;
    load('0);
    run_write(16'h0008, res);
    chk(res == 1 && used(mem) == 2, "R7 extra entry used", used(mem), 2);
    chk(e_ptr(mem, 0) == 3 && e_ptr(mem, 1) == 3, "R7 same cell", {e_ptr(mem, 0), e_ptr(mem, 1)}, {32'd3, 32'd3});
    chk(logical(mem) == 16'h0008, "R7 value", logical(mem), 16'h0008);
    run_write(16'h0000, res);
    chk(res == 1 && used(mem) == 2, "R11 override toggled", used(mem), 2);
    chk(logical(mem) == 16'h0000, "R11 value", logical(mem), 16'h0000);

    // stuck pointer cell in entry 0 (pointer bit 1 stuck at 1)
    stuck_m = '0; stuck_v = '0;
    stuck_m[5] = 1'b1; stuck_m[D + 1] = 1'b1; stuck_v[D + 1] = 1'b1;
    load('0);
    run_write(16'h0020, res);
    chk(res == 1 && used(mem) == 2, "R8 one more entry", used(mem), 2);
    chk(e_ptr(mem, 0) == 7 && e_repl(mem, 0) == 1'b0, "R8 harmless entry", {e_ptr(mem, 0), 31'd0, e_repl(mem, 0)}, {32'd7, 32'd0});
    chk(e_ptr(mem, 1) == 5, "R8 real repair", e_ptr(mem, 1), 5);
    chk(logical(mem) == 16'h0020, "R8 value", logical(mem), 16'h0020);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule